// File: doc/BRIEF.md
# Frame Sync Monitor with LED Flasher

This block judges, frame by frame, whether a serial receiver is locked to the incoming frame structure. An upstream stage gives it a one-cycle strobe per received frame, together with a bit that says whether that frame's alignment byte matched the expected pattern. From these the block keeps a local in-sync flag with hysteresis. A run of good frames is needed to declare lock. Once locked, the flag is only dropped when misses accumulate within a short sliding window of frames.

The far end reports its own lock state in each frame's overhead. The block samples that report on every frame strobe and combines it with the local flag. The result goes to two indicator outputs and to the two status bits that the transmit side inserts into the outgoing overhead byte. Both indicators are active-low and flash at a rate set by a prescaler. The prescaler advances on a slow time-base tick. The local indicator flashes while the local receiver is out of lock. The remote indicator flashes only while the local receiver is locked and the far end reports that it has lost lock.

Top module: `frame_sync_monitor`

## Requirements
- R1: After a synchronous active-low reset, local_sync is 0, both LED outputs are 1, ovh_status is 0 and the flash phase is 0.
- R2: While out of sync, local_sync rises in the cycle after the GAIN_FRAMES-th consecutive strobe with pattern_ok=1 (default 3). A strobe with pattern_ok=0 restarts that count.
- R3: While in sync, local_sync falls in the cycle after a strobe that brings the number of missed frames among the last LOSS_WINDOW strobes to LOSS_LIMIT (default 2 of 4). The strobe that triggers the check is counted among the last LOSS_WINDOW strobes.
- R4: When frame_stb is 0, pattern_ok and far_sync_bit have no effect. The sync decision and the status byte are unchanged.
- R5: Gaining sync clears the miss history, and losing sync clears the good-frame count. Lock therefore needs GAIN_FRAMES fresh good frames after any loss, and frames seen before the lock was gained are not counted as misses.
- R6: The flash phase toggles on every (BLINK_TC+1)-th cycle with time_tick=1. Cycles without a tick do not advance it.
- R7: led_local_n is 1 while local_sync is 1. Otherwise it is the inverse of the flash phase (0 means lit).
- R8: led_remote_n is 1 unless local_sync is 1 and the latched far-end bit is 0. In that case it is the inverse of the flash phase.
- R9: far_sync_bit is latched on every frame strobe; reset clears it. ovh_status bit 7 is the latched value ANDed with local_sync.
- R10: ovh_status bit 6 equals local_sync, and bits 5 to 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| pattern_ok | input | 1 | Frame alignment byte matched; valid with frame_stb |
| far_sync_bit | input | 1 | Far end's reported lock state; valid with frame_stb |
| time_tick | input | 1 | Slow time-base tick for the flash prescaler |
| local_sync | output | 1 | Local receiver in sync |
| led_local_n | output | 1 | Local indicator drive, active low |
| led_remote_n | output | 1 | Remote indicator drive, active low |
| ovh_status | output | 8 | Outgoing overhead status byte (bit 7 remote, bit 6 local) |

## Verification
The embedded assertions check properties that hold on every cycle. The sync flag changes only in the cycle after a strobe. It rises only after a good frame and falls only after a miss. The prescaler count never passes its terminal value, and the phase moves only on a tick. Neither LED is lit in a state where it must stay dark. What the assertions cannot see is whether the counts are exact: that exactly three goods gain lock, and that exactly two misses in a window of four lose it. The bench settles that with an exhaustive sweep over miss patterns from the locked state and from reset, compared against an arithmetic model. The same sweep checks the remote-flag gating and the flash phase against tick counts.

// File: rtl/syncmon_pkg.sv
// Shared constants and helpers for the frame sync monitor.
// Assumes: the overhead status byte is 8 bits wide, with the two flag
// positions fixed because the far end decodes them.
package syncmon_pkg;
    localparam int STATUS_W   = 8;
    localparam int REMOTE_POS = 7;
    localparam int LOCAL_POS  = 6;
    localparam int LED_COUNT  = 2;
    localparam int LED_LOCAL  = 0;
    localparam int LED_REMOTE = 1;

    // Population count of a miss history vector (up to 32 bits).
    function automatic int unsigned count_set(input logic [31:0] v, input int unsigned n);
        int unsigned c;
        c = 0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < n && v[i]) c = c + 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/syncmon_tracker.sv
// Frame lock tracker. It counts consecutive good frames to gain lock and
// keeps a sliding miss window to lose it.
// Assumes: frame_stb is a single-cycle pulse; pattern_ok is only valid
// alongside it. LOSS_WINDOW is between 2 and 32.
module syncmon_tracker #(
    parameter int GAIN_FRAMES = 3,
    parameter int LOSS_WINDOW = 4,
    parameter int LOSS_LIMIT  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic pattern_ok,
    output logic in_sync
);
    import syncmon_pkg::*;

    localparam int GOOD_W = $clog2(GAIN_FRAMES + 1);

    logic [GOOD_W-1:0]      good_cnt;
    logic [LOSS_WINDOW-1:0] miss_hist;
    logic [LOSS_WINDOW-1:0] hist_next;
    logic                   lose_now;
    logic                   gain_now;

    // Next miss window and the loss / gain decisions for this strobe.
    always_comb begin
        hist_next = {miss_hist[LOSS_WINDOW-2:0], ~pattern_ok};
        lose_now  = count_set(32'(hist_next), LOSS_WINDOW) >= LOSS_LIMIT;
        gain_now  = pattern_ok && (good_cnt == GOOD_W'(GAIN_FRAMES - 1));
    end

    // Lock state, good-frame counter and miss history, updated per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync   <= 1'b0;
            good_cnt  <= '0;
            miss_hist <= '0;
        end else if (frame_stb) begin
            if (!in_sync) begin
                miss_hist <= '0;
                if (!pattern_ok) begin
                    good_cnt <= '0;
                end else if (gain_now) begin
                    in_sync  <= 1'b1;
                    good_cnt <= '0;
                end else begin
                    good_cnt <= good_cnt + 1'b1;
                end
            end else begin
                good_cnt <= '0;
                if (lose_now) begin
                    in_sync   <= 1'b0;
                    miss_hist <= '0;
                end else begin
                    miss_hist <= hist_next;
                end
            end
        end
    end

    // R4: no frame strobe, no change of the lock decision.
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(in_sync));
    // R2: lock is only gained on a strobe carrying a good frame.
    p_gain_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(frame_stb && pattern_ok));
    // R3: lock is only lost on a strobe carrying a missed frame.
    p_loss_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sync) |-> $past(frame_stb && !pattern_ok));
    // R5: a good-frame run never outgrows the gain threshold.
    p_good_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        good_cnt < GOOD_W'(GAIN_FRAMES));
endmodule

// File: rtl/syncmon_blink_timer.sv
// Flash time base. A prescaler counts slow ticks and toggles a phase bit
// each time the count wraps.
// Assumes: time_tick is a single-cycle pulse from a slow reference.
module syncmon_blink_timer #(
    parameter int BLINK_TC = 124
) (
    input  logic clk,
    input  logic rst_n,
    input  logic time_tick,
    output logic phase
);
    localparam int CNT_W = (BLINK_TC < 1) ? 1 : $clog2(BLINK_TC + 1);

    logic [CNT_W-1:0] tick_cnt;

    // Prescaler count and phase toggle on terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            phase    <= 1'b0;
        end else if (time_tick) begin
            if (tick_cnt == CNT_W'(BLINK_TC)) begin
                tick_cnt <= '0;
                phase    <= ~phase;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // R6: the count stays within its terminal value.
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= CNT_W'(BLINK_TC));
    // R6: without a tick the phase holds.
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !time_tick |=> $stable(phase));
endmodule

// File: rtl/syncmon_led_drive.sv
// Active-low indicator driver. It gates the flash phase with an enable.
// Assumes: the output feeds an open-drain style pin; 1 means dark.
module syncmon_led_drive (
    input  logic enable,
    input  logic phase,
    output logic led_n
);
    // Lit (0) only when enabled and in the on half of the flash period.
    always_comb led_n = ~(enable & phase);
endmodule

// File: rtl/frame_sync_monitor.sv
// Frame sync monitor top. It tracks local frame lock, latches the far
// end's reported lock per frame, drives two flashing indicators and
// forms the outgoing overhead status bits.
// Assumes: frame_stb, pattern_ok and far_sync_bit come from the receive
// deframer in the same clock domain.
module frame_sync_monitor #(
    parameter int GAIN_FRAMES = 3,
    parameter int LOSS_WINDOW = 4,
    parameter int LOSS_LIMIT  = 2,
    parameter int BLINK_TC    = 124
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_stb,
    input  logic       pattern_ok,
    input  logic       far_sync_bit,
    input  logic       time_tick,
    output logic       local_sync,
    output logic       led_local_n,
    output logic       led_remote_n,
    output logic [7:0] ovh_status
);
    import syncmon_pkg::*;

    logic                 far_q;
    logic                 far_ok;
    logic                 phase;
    logic [LED_COUNT-1:0] led_en;
    logic [LED_COUNT-1:0] led_n;

    syncmon_tracker #(
        .GAIN_FRAMES (GAIN_FRAMES),
        .LOSS_WINDOW (LOSS_WINDOW),
        .LOSS_LIMIT  (LOSS_LIMIT)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .pattern_ok (pattern_ok),
        .in_sync    (local_sync)
    );

    syncmon_blink_timer #(
        .BLINK_TC (BLINK_TC)
    ) u_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .time_tick (time_tick),
        .phase     (phase)
    );

    // Far-end lock report, sampled once per received frame.
    always_ff @(posedge clk) begin
        if (!rst_n) far_q <= 1'b0;
        else if (frame_stb) far_q <= far_sync_bit;
    end

    // Far-end report is trusted only while the local receiver is locked.
    always_comb far_ok = far_q & local_sync;

    // Indicator enables: local flashes when unlocked, remote when the far end is lost.
    always_comb begin
        led_en             = '0;
        led_en[LED_LOCAL]  = ~local_sync;
        led_en[LED_REMOTE] = local_sync & ~far_q;
    end

    for (genvar g = 0; g < LED_COUNT; g++) begin : g_led
        syncmon_led_drive u_drv (
            .enable (led_en[g]),
            .phase  (phase),
            .led_n  (led_n[g])
        );
    end

    assign led_local_n  = led_n[LED_LOCAL];
    assign led_remote_n = led_n[LED_REMOTE];

    // Outgoing overhead status byte; unused positions stay zero.
    always_comb begin
        ovh_status             = '0;
        ovh_status[REMOTE_POS] = far_ok;
        ovh_status[LOCAL_POS]  = local_sync;
    end

    // R7: local indicator is dark while locked.
    p_local_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        local_sync |-> led_local_n);
    // R8: remote indicator is dark while unlocked.
    p_remote_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !local_sync |-> led_remote_n);
    // R8: both indicators are never lit together.
    p_one_lit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        led_local_n || led_remote_n);
    // R9: far-end report holds between frame strobes.
    p_far_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(far_q));
endmodule

// File: tb/frame_sync_monitor_bench.sv
module frame_sync_monitor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TC         = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       pattern_ok = 1'b0;
    logic       far_sync_bit = 1'b0;
    logic       time_tick = 1'b0;
    logic       local_sync;
    logic       led_local_n;
    logic       led_remote_n;
    logic [7:0] ovh_status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model state
    bit       m_sync;
    int       m_good;
    bit [3:0] m_hist;
    bit       m_far;
    bit       m_ph;
    int       m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_sync_monitor #(
        .GAIN_FRAMES (3),
        .LOSS_WINDOW (4),
        .LOSS_LIMIT  (2),
        .BLINK_TC    (TC)
    ) u_frame_sync_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_stb    (frame_stb),
        .pattern_ok   (pattern_ok),
        .far_sync_bit (far_sync_bit),
        .time_tick    (time_tick),
        .local_sync   (local_sync),
        .led_local_n  (led_local_n),
        .led_remote_n (led_remote_n),
        .ovh_status   (ovh_status)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_sync = 0; m_good = 0; m_hist = 0; m_far = 0; m_ph = 0; m_pc = 0;
    endtask

    task automatic check_all();
        chk({7'b0, local_sync}, {7'b0, m_sync}, "R3 local_sync");
        chk({7'b0, led_local_n}, {7'b0, m_sync ? 1'b1 : !m_ph}, "R7 led_local_n");
        chk({7'b0, led_remote_n}, {7'b0, (m_sync && !m_far) ? !m_ph : 1'b1}, "R8 led_remote_n");
        chk(ovh_status, {m_far & m_sync, m_sync, 6'b0}, "R9 R10 ovh_status");
    endtask

    // One clock: drive inputs at the falling edge, update model, check at the next falling edge.
    task automatic cyc(input bit stb, input bit ok, input bit far, input bit tk);
        bit [3:0] h;
        frame_stb = stb; pattern_ok = ok; far_sync_bit = far; time_tick = tk;
        @(posedge clk);
        if (stb) begin
            if (!m_sync) begin
                m_hist = 0;
                if (!ok) m_good = 0;
                else if (m_good == 2) begin m_sync = 1; m_good = 0; end
                else m_good++;
            end else begin
                m_good = 0;
                h = {m_hist[2:0], !ok};
                if ($countones(h) >= 2) begin m_sync = 0; m_hist = 0; end
                else m_hist = h;
            end
            m_far = far;
        end
        if (tk) begin
            if (m_pc == TC) begin m_pc = 0; m_ph = !m_ph; end
            else m_pc++;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset();
        frame_stb = 0; pattern_ok = 0; far_sync_bit = 0; time_tick = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk({7'b0, local_sync}, 8'd0, "R1 local_sync");
        chk({6'b0, led_local_n, led_remote_n}, 8'd3, "R1 leds");
        chk(ovh_status, 8'd0, "R1 ovh_status");

        // R6: phase toggles every TC+1 ticks, seen on the local LED while unlocked
        for (int i = 0; i < 12; i++) begin
            cyc(0, 0, 0, 1);
            chk({7'b0, led_local_n}, {7'b0, !(((i + 1) / (TC + 1)) % 2 == 1)}, "R6 phase");
            cyc(0, 0, 0, 0);
        end

        // R2: two goods, a miss restarts, then three goods lock
        do_reset();
        cyc(1, 1, 1, 0); cyc(1, 1, 1, 0); cyc(1, 0, 1, 0);
        chk({7'b0, local_sync}, 8'd0, "R2 miss restarts count");
        cyc(1, 1, 1, 0); cyc(1, 1, 1, 0);
        chk({7'b0, local_sync}, 8'd0, "R2 two goods not enough");
        cyc(1, 1, 1, 0);
        chk({7'b0, local_sync}, 8'd1, "R2 lock after three goods");

        // R4: inputs without a strobe are ignored
        for (int i = 0; i < 10; i++) begin
            cyc(0, 0, i[0], 0);
            chk({7'b0, local_sync}, 8'd1, "R4 no strobe keeps lock");
            chk(ovh_status, 8'hC0, "R4 status unchanged");
        end

        // R3: miss, good, good, miss loses lock on the last miss
        cyc(1, 0, 1, 0); cyc(1, 1, 1, 0); cyc(1, 1, 1, 0);
        chk({7'b0, local_sync}, 8'd1, "R3 single miss tolerated");
        cyc(1, 0, 1, 0);
        chk({7'b0, local_sync}, 8'd0, "R3 two misses in four lose lock");

        // R5: after loss, three fresh goods are needed; history cleared on lock
        cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
        chk({7'b0, local_sync}, 8'd0, "R5 not yet relocked");
        cyc(1, 1, 0, 0);
        chk({7'b0, local_sync}, 8'd1, "R5 relocked");
        cyc(1, 0, 0, 0);
        chk({7'b0, local_sync}, 8'd1, "R5 old misses forgotten");
        // R8: far end lost while locked; remote LED follows phase
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1);
        chk({7'b0, led_remote_n}, {7'b0, !m_ph}, "R8 remote flashes");
        // R9: far report latched on strobe
        cyc(1, 1, 1, 0);
        chk(ovh_status, 8'hC0, "R9 far flag set");

        // Exhaustive sweep of 8-frame miss patterns from locked and unlocked states
        for (int start = 0; start < 2; start++) begin
            for (int p = 0; p < 256; p++) begin
                do_reset();
                if (start == 1) begin
                    cyc(1, 1, 1, 0); cyc(1, 1, 1, 0); cyc(1, 1, 1, 0);
                end
                for (int k = 0; k < 8; k++) begin
                    cyc(1, p[k], p[(k + 3) % 8] ^ start[0], (k + p) % 3 == 0);
                    cyc(0, !p[k], p[k], (k % 2) == 1);
                end
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule